// File: doc/BRIEF.md
# Mixed-Sign Widening Multiply-Accumulate Lane Array

This block performs one step of a long widening dot-product update on a row of 32-bit accumulators. It receives a vector of bytes read as unsigned integers, a vector of bytes read as two's-complement integers, one accumulator row, and a two-bit sub-row selector. Each 32-bit lane takes one byte from each source vector and multiplies them. It then adds the product into its accumulator element and returns the updated row.

The lane count follows the vector width parameter. A surrounding sequencer walks the selector through 0, 1, 2 and 3, one value for each of four consecutive accumulator rows. Lane `e` always reads byte `4*e + sel` of both sources, so the four passes together consume every byte. The block holds one result register and uses a valid/ready handshake on both sides. A new operation is accepted in the same cycle that the held result drains.

Top module: `mixmac_lanes`

## Requirements
- R1: Each byte of `src_u` is read as an unsigned value from 0 to 255. With `src_u` bytes at 0xFF, `src_s` bytes at 0x01 and a zero accumulator, every lane returns 255.
- R2: Each byte of `src_s` is read as a two's-complement value from -128 to 127. With `src_u` bytes at 0x01, `src_s` bytes at 0x80 and a zero accumulator, every lane returns 0xFFFFFF80.
- R3: Each lane result equals the lane's accumulator plus the product, taken modulo 2^32, with no saturation. An accumulator of 0xFFFFFFFF plus a product of 1 gives 0.
- R4: With selector value `i`, lane `e` (bits `32*e+31 : 32*e`) uses byte `4*e+i` (bits `8*(4*e+i)+7 : 8*(4*e+i)`) of both sources. Bytes at other positions have no effect.
- R5: Every lane is written on every accepted operation. There is no per-lane enable.
- R6: `out_valid` rises in the cycle after an accepted input (`in_valid && in_ready`). While `out_valid` is high and `out_ready` is low, `out_valid` and `acc_out` hold steady.
- R7: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R8: After reset, `out_valid` is low and `acc_out` is all zeros.
- R9: Without a new accepted input, a result taken with `out_ready` high clears `out_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands offered |
| in_ready | output | 1 | Block can accept operands |
| src_u | input | VL | Unsigned byte vector |
| src_s | input | VL | Signed byte vector |
| acc_in | input | VL | Accumulator row, 32-bit lanes |
| row_sel | input | 2 | Sub-row selector i |
| out_valid | output | 1 | Result row held |
| out_ready | input | 1 | Consumer takes result |
| acc_out | output | VL | Updated accumulator row |

## Verification
The block has only two pieces of internal state, the held result and its valid flag. A wrong flag shows up as a handshake mismatch on `out_valid` or `in_ready` in the same cycle, for example a lost or duplicated row under back-pressure. A wrong byte pick, sign treatment or carry shows in `acc_out` on the first cycle of `out_valid` for that operation. The reference model compares both the handshake and the data every cycle. Any of these faults is therefore reported within one clock of the operation that exposes it.

// File: rtl/mixmac_lanes.sv
module mixmac_lanes #(
  parameter int VL = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VL-1:0] src_u,
  input  logic [VL-1:0] src_s,
  input  logic [VL-1:0] acc_in,
  input  logic [1:0]    row_sel,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VL-1:0] acc_out
);
  localparam int LANES = VL / 32;

  logic [VL-1:0] nxt;
  logic          fire;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    logic [7:0]         ub, sb;
    logic signed [8:0]  ua, sa;
    logic signed [17:0] prod;

    assign ub   = src_u[8*(4*e + int'(row_sel)) +: 8];
    assign sb   = src_s[8*(4*e + int'(row_sel)) +: 8];
    assign ua   = {1'b0, ub};
    assign sa   = {sb[7], sb};
    assign prod = ua * sa;
    assign nxt[32*e +: 32] = acc_in[32*e +: 32] + {{14{prod[17]}}, prod};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      acc_out   <= nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mixmac_lanes_chk.sv
module mixmac_lanes_chk #(
  parameter int VL = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [VL-1:0] acc_out
);
  a_r6_valid_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(acc_out)));

  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r7_free: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind mixmac_lanes mixmac_lanes_chk #(.VL(VL)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .acc_out(acc_out)
);

// File: tb/test_mixmac_lanes.sv
module test_mixmac_lanes;
  localparam int VL = 128;
  localparam int LANES = VL / 32;
  localparam int PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VL-1:0] src_u = '0;
  logic [VL-1:0] src_s = '0;
  logic [VL-1:0] acc_in = '0;
  logic [1:0]    row_sel = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [VL-1:0] acc_out;

  int total = 0;
  int bad = 0;
  string tag = "R8";

  logic          m_valid = 1'b0;
  logic [VL-1:0] m_data = '0;

  mixmac_lanes #(.VL(VL)) i_mixmac_lanes (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_u(src_u), .src_s(src_s), .acc_in(acc_in), .row_sel(row_sel),
    .out_valid(out_valid), .out_ready(out_ready), .acc_out(acc_out)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [VL-1:0] model(input logic [VL-1:0] u, input logic [VL-1:0] s,
                                          input logic [VL-1:0] a, input int i);
    logic [VL-1:0] r;
    for (int e = 0; e < LANES; e++) begin
      int ui = int'(u[8*(4*e+i) +: 8]);
      int si = int'($signed(s[8*(4*e+i) +: 8]));
      logic [31:0] p = 32'(ui * si);
      r[32*e +: 32] = a[32*e +: 32] + p;
    end
    return r;
  endfunction

  task automatic cycle(input logic [VL-1:0] u, input logic [VL-1:0] s, input logic [VL-1:0] a,
                       input logic [1:0] i, input logic v, input logic rdy);
    logic fire;
    @(negedge clk);
    src_u = u; src_s = s; acc_in = a; row_sel = i; in_valid = v; out_ready = rdy;
    #1;
    total++;
    if (out_valid !== m_valid || in_ready !== (!m_valid || rdy)) begin
      bad++;
      $display("FAIL %s handshake: valid=%b ready=%b expected valid=%b ready=%b",
               tag, out_valid, in_ready, m_valid, (!m_valid || rdy));
    end
    if (m_valid) begin
      total++;
      if (acc_out !== m_data) begin
        bad++;
        $display("FAIL %s data: got %h expected %h", tag, acc_out, m_data);
      end
    end
    fire = v && (!m_valid || rdy);
    if (fire) begin
      m_valid = 1'b1;
      m_data = model(u, s, a, int'(i));
    end else if (rdy) begin
      m_valid = 1'b0;
    end
  endtask

  function automatic logic [VL-1:0] rnd();
    logic [VL-1:0] r;
    for (int k = 0; k < VL/32; k++) r[32*k +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || acc_out !== '0) begin
      bad++;
      $display("FAIL R8 reset: valid=%b data=%h expected 0 and 0", out_valid, acc_out);
    end
    rst_n = 1'b1;

    tag = "R1";
    cycle({(VL/8){8'hFF}}, {(VL/8){8'h01}}, '0, 2'd0, 1'b1, 1'b1);
    tag = "R2";
    cycle({(VL/8){8'h01}}, {(VL/8){8'h80}}, '0, 2'd1, 1'b1, 1'b1);
    tag = "R3";
    cycle({(VL/8){8'h01}}, {(VL/8){8'h01}}, {(VL/32){32'hFFFFFFFF}}, 2'd2, 1'b1, 1'b1);
    tag = "R2 extreme";
    cycle({(VL/8){8'hFF}}, {(VL/8){8'h80}}, {(VL/32){32'h80000000}}, 2'd3, 1'b1, 1'b1);
    tag = "R9";
    cycle('0, '0, '0, 2'd0, 1'b0, 1'b1);
    cycle('0, '0, '0, 2'd0, 1'b0, 1'b1);

    tag = "R4";
    for (int i = 0; i < 4; i++) begin
      logic [VL-1:0] u = '0, s = '0;
      for (int e = 0; e < LANES; e++) begin
        u[8*(4*e+i) +: 8] = 8'(e + 3);
        s[8*(4*e+i) +: 8] = 8'hFE;
      end
      cycle(u, s, rnd(), 2'(i), 1'b1, 1'b1);
      cycle(~u, s, rnd(), 2'(i ^ 1), 1'b1, 1'b1);
    end

    tag = "R5";
    for (int k = 0; k < 40; k++) cycle(rnd(), rnd(), rnd(), 2'($urandom), 1'b1, 1'b1);

    tag = "R6";
    cycle(rnd(), rnd(), rnd(), 2'd1, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) cycle(rnd(), rnd(), rnd(), 2'($urandom), 1'b1, 1'b0);
    cycle(rnd(), rnd(), rnd(), 2'd2, 1'b1, 1'b1);

    tag = "R7";
    for (int k = 0; k < 300; k++)
      cycle(rnd(), rnd(), rnd(), 2'($urandom), 1'($urandom), 1'($urandom));
    cycle('0, '0, '0, 2'd0, 1'b0, 1'b1);
    cycle('0, '0, '0, 2'd0, 1'b0, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule